// File: doc/BRIEF.md
# Reset and Power Mode Controller

This block watches the external active-high reset pin of a small microcontroller, filters it by length, and produces the internal reset. It also holds the power control register. That register has two low-power request bits: one for idle and one for power-down. From the register it derives the clock enables for the CPU and for the peripherals. It also forces the external bus strobes and the two address/data ports into the state required for the active mode. The oscillator clock enters the block directly. The block divides it by two to form the internal state clock, so the duty cycle of the input does not matter.

The CPU writes the power control register to enter a low-power mode. In idle, the CPU clock stops and the peripherals keep running. An enabled interrupt request returns the part to normal operation, and its service routine then runs. In power-down, every clock enable is held off. Only a recognized pin reset brings the part back. The pin overrides depend on the mode and on whether program memory is internal or external.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: A reset is recognized when `rst_pin` is sampled high on 24 consecutive clock edges. `core_rst` rises on the edge after the 24th high sample, stays high while the pin stays high, and falls two edges after the first low sample.
- R2: A high run of 23 samples or fewer gives no reset. A single low sample clears the count, so two runs split by one low cycle do not add together.
- R3: While `core_rst` is high, the control register is cleared to 0x00 on every edge, and writes have no effect.
- R4: Control register fields: bit 0 is the idle request, bit 1 is the power-down request, bits 3:2 are general flags, and bit 7 is the baud doubling bit. Bits 6:4 are not stored and read as 0. A write stores `reg_wdata` masked with 0x8F, and `pcon_q` shows the new value after the write edge.
- R5: A write that sets bit 0 and bit 1 together enters power-down only (for example, 0x03 reads back as 0x02).
- R6: In normal operation, `cpu_clk_en` and `periph_clk_en` are high together on every second clock cycle (divide-by-two).
- R7: In idle, `cpu_clk_en` stays low and `periph_clk_en` keeps its divide-by-two pattern.
- R8: In idle, `irq_pending` clears the idle bit on the next edge, and normal operation resumes. Register writes are ignored in idle and in power-down.
- R9: In power-down, both clock enables stay low, and `irq_pending` and writes leave the register unchanged. Only a recognized reset exits.
- R10: In idle, `pin_hold`=1, `ale_level`=1, `psen_level`=1, and both `p0_float` and `p2_addr` equal `ext_prog`.
- R11: In power-down, `pin_hold`=1, `ale_level`=0, `psen_level`=0, `p0_float` equals `ext_prog`, and `p2_addr`=0.
- R12: In normal operation, `pin_hold`=0, `p0_float`=0 and `p2_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | External reset pin, active high |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| irq_pending | input | 1 | An enabled interrupt is requesting service |
| ext_prog | input | 1 | Program is running from external memory |
| core_rst | output | 1 | Internal reset after length filtering |
| pcon_q | output | 8 | Control register contents |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pin_hold | output | 1 | Pin overrides active (low-power mode) |
| ale_level | output | 1 | Forced level for the address latch strobe |
| psen_level | output | 1 | Forced level for the program read strobe |
| p0_float | output | 1 | Release the low address/data port |
| p2_addr | output | 1 | High port keeps driving the address byte |

## Verification
The hardest situations to reach from the ports are the exact edges of the reset filter: a 23-sample pulse against a 24-sample pulse, and a long pulse broken by a single low cycle. The stimulus drives the pin for a counted number of falling edges and samples `core_rst` one cycle after release. Power-down also needs care, because the only way out is a recognized reset. Every vector in the table therefore opens with a full-length reset pulse before it writes the register.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int CTRL_W   = 8;
  localparam int BIT_IDLE = 0;
  localparam int BIT_PDN  = 1;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h8F;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_t;
endpackage

// File: rtl/pwr_rst_filter.sv
module pwr_rst_filter #(
  parameter int HOLD_CYCLES = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_i,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic          pin_s_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pin_s_q)           cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_s_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pin_s_q <= pin_i;
      cnt_q   <= cnt_d;
    end
  end

  assign rst_o = (cnt_q == LIMIT);
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              core_rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              irq,
  output logic [CTRL_W-1:0] ctrl_q,
  output pmode_t            mode
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [CTRL_W-1:0] wr_val;

  always_comb begin
    wr_val = wdata & CTRL_MASK;
    if (wr_val[BIT_PDN]) wr_val[BIT_IDLE] = 1'b0;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (core_rst) begin
      ctrl_d = '0;
    end else if (ctrl_q[BIT_PDN]) begin
      ctrl_d = ctrl_q;
    end else if (ctrl_q[BIT_IDLE]) begin
      if (irq) ctrl_d[BIT_IDLE] = 1'b0;
    end else if (we) begin
      ctrl_d = wr_val;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    if (ctrl_q[BIT_PDN])       mode = MODE_PDOWN;
    else if (ctrl_q[BIT_IDLE]) mode = MODE_IDLE;
    else                       mode = MODE_RUN;
  end
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  pmode_t mode,
  output logic   cpu_en,
  output logic   per_en
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (mode != MODE_PDOWN) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign cpu_en = phase_q && (mode == MODE_RUN);
  assign per_en = phase_q && (mode != MODE_PDOWN);
endmodule

// File: rtl/pwr_pin_mux.sv
module pwr_pin_mux
  import pwr_pkg::*;
(
  input  pmode_t mode,
  input  logic   ext_prog,
  output logic   hold,
  output logic   ale,
  output logic   psen,
  output logic   p0_flt,
  output logic   p2_adr
);
  always_comb begin
    hold   = 1'b0;
    ale    = 1'b1;
    psen   = 1'b1;
    p0_flt = 1'b0;
    p2_adr = 1'b0;
    unique case (mode)
      MODE_IDLE: begin
        hold   = 1'b1;
        p0_flt = ext_prog;
        p2_adr = ext_prog;
      end
      MODE_PDOWN: begin
        hold   = 1'b1;
        ale    = 1'b0;
        psen   = 1'b0;
        p0_flt = ext_prog;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pwr_pkg::*;
#(
  parameter int RST_HOLD = 24
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_pin,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  input  logic       irq_pending,
  input  logic       ext_prog,
  output logic       core_rst,
  output logic [7:0] pcon_q,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       pin_hold,
  output logic       ale_level,
  output logic       psen_level,
  output logic       p0_float,
  output logic       p2_addr
);
  pmode_t mode;

  pwr_rst_filter #(.HOLD_CYCLES(RST_HOLD)) u_filt (
    .clk   (clk),
    .por_n (por_n),
    .pin_i (rst_pin),
    .rst_o (core_rst)
  );

  pwr_mode_reg u_mreg (
    .clk      (clk),
    .por_n    (por_n),
    .core_rst (core_rst),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .irq      (irq_pending),
    .ctrl_q   (pcon_q),
    .mode     (mode)
  );

  pwr_clk_gate u_cg (
    .clk    (clk),
    .por_n  (por_n),
    .mode   (mode),
    .cpu_en (cpu_clk_en),
    .per_en (periph_clk_en)
  );

  pwr_pin_mux u_pins (
    .mode     (mode),
    .ext_prog (ext_prog),
    .hold     (pin_hold),
    .ale      (ale_level),
    .psen     (psen_level),
    .p0_flt   (p0_float),
    .p2_adr   (p2_addr)
  );
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_pin,
  input logic       irq_pending,
  input logic       core_rst,
  input logic [7:0] pcon_q,
  input logic       cpu_clk_en,
  input logic       periph_clk_en,
  input logic       pin_hold,
  input logic       p2_addr
);
  assert_rise_needs_pin_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst) |-> $past(rst_pin, 2));

  assert_reset_clears_R3: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> (pcon_q == 8'h00));

  assert_unused_bits_zero_R4: assert property (@(posedge clk) disable iff (!por_n)
    pcon_q[6:4] == 3'b000);

  assert_pdown_wins_R5: assert property (@(posedge clk) disable iff (!por_n)
    pcon_q[1] |-> !pcon_q[0]);

  assert_idle_cpu_off_R7: assert property (@(posedge clk) disable iff (!por_n)
    cpu_clk_en |-> !pin_hold);

  assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!por_n)
    (pcon_q[0] && irq_pending && !core_rst) |=> !pcon_q[0]);

  assert_pdown_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    (pcon_q[1] && !core_rst) |=> pcon_q[1]);

  assert_pdown_no_clk_R9: assert property (@(posedge clk) disable iff (!por_n)
    pcon_q[1] |-> !periph_clk_en);

  assert_pdown_no_addr_R11: assert property (@(posedge clk) disable iff (!por_n)
    pcon_q[1] |-> !p2_addr);
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .rst_pin       (rst_pin),
  .irq_pending   (irq_pending),
  .core_rst      (core_rst),
  .pcon_q        (pcon_q),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .pin_hold      (pin_hold),
  .p2_addr       (p2_addr)
);

// File: tb/pwr_rst_ctrl_tb.sv
module pwr_rst_ctrl_tb;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_pin = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       irq_pending = 1'b0;
  logic       ext_prog = 1'b0;
  logic       core_rst;
  logic [7:0] pcon_q;
  logic       cpu_clk_en, periph_clk_en, pin_hold;
  logic       ale_level, psen_level, p0_float, p2_addr;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pwr_rst_ctrl u_dut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .irq_pending(irq_pending), .ext_prog(ext_prog),
    .core_rst(core_rst), .pcon_q(pcon_q), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .pin_hold(pin_hold), .ale_level(ale_level),
    .psen_level(psen_level), .p0_float(p0_float), .p2_addr(p2_addr)
  );

  typedef struct packed {
    logic [7:0] wr;
    logic       ext;
    logic [7:0] pcon;
    logic       hold;
    logic       ale;
    logic       psen;
    logic       p0f;
    logic       p2a;
    logic [2:0] ncpu;
    logic [2:0] nper;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 3'd2},
    '{8'h01, 1'b0, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 3'd2},
    '{8'h01, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 3'd2},
    '{8'h02, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0},
    '{8'h02, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0},
    '{8'h03, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0},
    '{8'hF5, 1'b0, 8'h85, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 3'd2},
    '{8'h8C, 1'b1, 8'h8C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd2, 3'd2}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Holds the pin high for n falling edges, then samples core_rst one cycle after release.
  task automatic pin_pulse(input int n, input bit exp_rst, input string req);
    rst_pin = 1'b1;
    repeat (n) @(negedge clk);
    rst_pin = 1'b0;
    @(negedge clk);
    check(req, core_rst, exp_rst);
    repeat (2) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] v);
    reg_wdata = v;
    reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic count_en(output int ncpu, output int nper);
    ncpu = 0;
    nper = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ncpu += int'(cpu_clk_en);
      nper += int'(periph_clk_en);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    int nc, np;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R3 reset state pcon", pcon_q, 8'h00);
    check("R1 reset state core_rst", core_rst, 0);
    check("R12 reset state hold", pin_hold, 0);

    for (int v = 0; v < NV; v++) begin
      pin_pulse(24, 1'b1, "R1 vector reset");
      ext_prog = VEC[v].ext;
      write_reg(VEC[v].wr);
      check("R4 R5 pcon readback", pcon_q, VEC[v].pcon);
      check("R10 R11 R12 pin_hold", pin_hold, VEC[v].hold);
      check("R10 R11 ale_level", ale_level, VEC[v].ale);
      check("R10 R11 psen_level", psen_level, VEC[v].psen);
      check("R10 R11 R12 p0_float", p0_float, VEC[v].p0f);
      check("R10 R11 R12 p2_addr", p2_addr, VEC[v].p2a);
      count_en(nc, np);
      check("R6 R7 R9 cpu_clk_en count", nc, VEC[v].ncpu);
      check("R6 R7 R9 periph_clk_en count", np, VEC[v].nper);
    end

    // R2: short pulses and a pulse split by one low cycle
    pin_pulse(24, 1'b1, "R1 clear");
    ext_prog = 1'b0;
    write_reg(8'h80);
    pin_pulse(23, 1'b0, "R2 23-cycle pulse");
    check("R2 register kept", pcon_q, 8'h80);
    rst_pin = 1'b1;
    repeat (20) @(negedge clk);
    rst_pin = 1'b0;
    @(negedge clk);
    pin_pulse(20, 1'b0, "R2 split pulse");
    check("R2 register kept after split", pcon_q, 8'h80);
    pin_pulse(40, 1'b1, "R1 long pulse");
    check("R3 cleared by reset", pcon_q, 8'h00);

    // R3: writes during core_rst ignored
    rst_pin = 1'b1;
    repeat (25) @(negedge clk);
    check("R1 core_rst held while pin high", core_rst, 1);
    write_reg(8'h8C);
    check("R3 write ignored in reset", pcon_q, 8'h00);
    rst_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 core_rst released", core_rst, 0);

    // R8: writes ignored in idle, interrupt wakes
    write_reg(8'h01);
    write_reg(8'h80);
    check("R8 write ignored in idle", pcon_q, 8'h01);
    irq_pending = 1'b1;
    @(negedge clk);
    irq_pending = 1'b0;
    check("R8 irq ends idle", pcon_q, 8'h00);
    count_en(nc, np);
    check("R8 cpu clock resumes", nc, 2);

    // R9: power-down ignores irq and writes, reset exits
    write_reg(8'h02);
    irq_pending = 1'b1;
    repeat (3) @(negedge clk);
    irq_pending = 1'b0;
    check("R9 irq ignored in power-down", pcon_q, 8'h02);
    write_reg(8'h00);
    check("R9 write ignored in power-down", pcon_q, 8'h02);
    pin_pulse(24, 1'b1, "R9 reset in power-down");
    check("R9 reset exits power-down", pcon_q, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule